// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the slave side of a two-wire serial bus. It gives a bus master access to four 16-bit registers that sit outside it. Both bus lines are oversampled on the system clock through synchronisers. Edge detectors find the start, repeated-start and stop conditions and the clock edges.

A master first addresses the slave. A write then carries a pointer byte, which selects one register, and may carry data bytes after it. A read returns the register that the stored pointer selects. The pointer survives between transactions, so repeated reads need no new pointer. A repeated start after a pointer byte turns the transaction into a read of the newly selected register.

The configuration register moves one byte per transfer. The other three registers move two bytes, high byte first. The slave acts on the bus only by pulling SDA low through an open-drain enable. On the register side it presents a register select, a write strobe with its data, and a read-data input.

Top module: `twi_ptr_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins address reception from any state, including in the middle of a byte. A stop condition (SDA rising while SCL is high) releases SDA and returns the slave to idle. After reset SDA is released, no write strobe is issued, and the select is 0.
- R2: The slave pulls SDA low during the ninth clock after the address byte only when the seven address bits, MSB first, equal 1001 followed by `dev_strap[2:0]`. On a mismatch it drives nothing until the next start.
- R3: On a write, the byte after the address is a pointer. If bits 7..2 of the pointer are zero, the slave acknowledges it and bits 1..0 become the new select. Otherwise the slave does not acknowledge, keeps the old select, and ignores everything up to the next start.
- R4: The select is kept across transactions and is visible on `reg_sel`. A read with no new pointer returns the previously selected register.
- R5: Select 0 is the temperature register (two bytes, read-only). Select 1 is the configuration register (one byte). Selects 2 and 3 are the lower and upper thresholds (two bytes each).
- R6: For selects 2 and 3, the slave acknowledges both data bytes. It then issues one `wr_en` pulse with `wr_data` = {first byte, second byte}. If a stop follows after only one data byte, no strobe is issued.
- R7: A configuration write issues one `wr_en` pulse after its data byte is acknowledged, with `wr_data` = {byte, 8'h00}.
- R8: Data bytes written while select 0 is active are acknowledged but produce no `wr_en`.
- R9: A read sends bits MSB first. A two-byte register sends `rd_data[15:8]` and then `rd_data[7:0]`. The configuration register sends only `rd_data[15:8]`. `rd_data` is captured once, when the address is acknowledged.
- R10: After the master leaves SDA high in the acknowledge slot of a read (no acknowledge), the slave keeps SDA released until the next start.
- R11: A pointer byte followed by a repeated start and a read address returns data from the register just selected.
- R12: The slave's SDA pull-down changes only in the cycle after an SCL falling edge, a start or a stop, so it never moves while SCL is high.
- R13: `wr_en` lasts one cycle per committed write and is never raised while select 0 is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as sensed at the pin |
| sda_in | input | 1 | Bus data line as sensed at the pin |
| dev_strap | input | 3 | Low three bits of the slave address |
| sda_pull | output | 1 | When high, the SDA open-drain driver pulls low |
| reg_sel | output | 2 | Stored pointer, which selects the register |
| wr_en | output | 1 | One-cycle write strobe for the selected register |
| wr_data | output | 16 | Data for the write strobe |
| rd_data | input | 16 | Contents of the selected register |

## Verification
A bus-master model in the bench drives the main function with several kinds of transaction:
- Correct addresses and wrong addresses, where the wrong ones differ in either the fixed nibble or the strap bits.
- Legal and illegal pointer values.
- Writes of full length, writes cut short by a stop, and writes to the read-only register.
- Reads with and without a preceding pointer, and a start issued in the middle of a byte.

Comparing the acknowledge bits and the write strobes separates the three outcomes: a refused transaction, an accepted but discarded write, and a committed write. Read-back values show whether the pointer was kept, updated or changed by mistake. The length of each read shows whether the one-byte and two-byte rules are applied to the right register.

// File: rtl/twi_pkg.sv
// Shared constants, register map and state type for the two-wire slave.
// Assumes registers are exactly two bytes wide.
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int PTR_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [PTR_W-1:0] SEL_TEMP = 2'd0;
    localparam logic [PTR_W-1:0] SEL_CFG  = 2'd1;
    localparam logic [PTR_W-1:0] SEL_LOW  = 2'd2;
    localparam logic [PTR_W-1:0] SEL_HIGH = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;

    // True for the register that moves a single byte per transfer.
    function automatic logic sel_is_short(input logic [PTR_W-1:0] sel);
        return sel == SEL_CFG;
    endfunction
endpackage

// File: rtl/twi_line_sync.sv
// Multi-stage synchroniser with edge detection for a group of bus lines.
// Assumes the lines idle high, so the stages reset to one and no edge is
// reported after reset. STAGES must be at least 1.
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES:0] chain;

        // Shift the pin value through the synchroniser plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], din[l]};
        end

        assign lvl[l]  = chain[STAGES-1];
        assign rise[l] = chain[STAGES-1] & ~chain[STAGES];
        assign fall[l] = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/twi_bus_cond.sv
// Finds start and stop conditions from synchronised line events.
// Assumes SDA edges never coincide with SCL edges on a legal bus.
module twi_bus_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_evt,
    output logic stop_evt
);
    // An SDA edge while SCL is high is a bus condition, not data.
    always_comb begin
        start_evt = sda_fall & scl_lvl;
        stop_evt  = sda_rise & scl_lvl;
    end
endmodule

// File: rtl/twi_ptr_fsm.sv
// Protocol engine: address match, pointer handling, byte reception with
// acknowledge, byte transmission and write commit. Works on single-cycle
// SCL edge events; assumes each SCL phase lasts several system clocks.
module twi_ptr_fsm
    import twi_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [REG_W-1:0]  rd_data,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  sel,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_data
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    twi_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] hold;
    logic [REG_W-1:0]  rbuf;
    logic [1:0]        wbytes;
    logic              rw;
    logic              ridx;
    logic              mack;

    // Single sequential process: bus conditions first, then per-state work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            hold     <= '0;
            rbuf     <= '0;
            wbytes   <= '0;
            rw       <= 1'b0;
            ridx     <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            sel      <= SEL_TEMP;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_evt) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_evt) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (sh[BYTE_W-1:1] == dev_addr) begin
                                    rw       <= sh[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                if (sh[BYTE_W-1:PTR_W] == '0) begin
                                    sel      <= sh[PTR_W-1:0];
                                    wbytes   <= '0;
                                    sda_pull <= 1'b1;
                                    state    <= ST_PTR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                rbuf     <= rd_data;
                                tx       <= rd_data[REG_W-1 -: BYTE_W];
                                sda_pull <= ~rd_data[REG_W-1];
                                ridx     <= 1'b0;
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                            if (sel_is_short(sel)) begin
                                if (wbytes == 2'd0) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= {sh, {BYTE_W{1'b0}}};
                                end
                            end else if (sel != SEL_TEMP) begin
                                if (wbytes == 2'd0) begin
                                    hold <= sh;
                                end else if (wbytes == 2'd1) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= {hold, sh};
                                end
                            end
                            if (wbytes != 2'd3) wbytes <= wbytes + 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                cnt      <= '0;
                                sda_pull <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                tx       <= {tx[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~tx[BYTE_W-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack && !sel_is_short(sel) && !ridx) begin
                                ridx     <= 1'b1;
                                tx       <= rbuf[BYTE_W-1:0];
                                sda_pull <= ~rbuf[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_ptr_slave.sv
// Top of the pointer-addressed two-wire slave. Synchronises the bus lines,
// finds bus conditions and runs the protocol engine. The registers live
// outside; rd_data must follow reg_sel within the same cycle.
module twi_ptr_slave
    import twi_pkg::*;
#(
    parameter int          STRAP_W     = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_ID      = 4'b1001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] dev_strap,
    output logic               sda_pull,
    output logic [PTR_W-1:0]   reg_sel,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_data,
    input  logic [REG_W-1:0]   rd_data
);
    localparam int ADDR_W = 4 + STRAP_W;
    localparam int L_SCL  = 0;
    localparam int L_SDA  = 1;

    logic [1:0] lvl_w, rise_w, fall_w;
    logic       start_w, stop_w, scl_fall_w;

    twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_in, scl_in}),
        .lvl  (lvl_w),
        .rise (rise_w),
        .fall (fall_w)
    );

    twi_bus_cond u_cond (
        .scl_lvl  (lvl_w[L_SCL]),
        .sda_rise (rise_w[L_SDA]),
        .sda_fall (fall_w[L_SDA]),
        .start_evt(start_w),
        .stop_evt (stop_w)
    );

    assign scl_fall_w = fall_w[L_SCL];

    twi_ptr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (rise_w[L_SCL]),
        .scl_fall (scl_fall_w),
        .sda_lvl  (lvl_w[L_SDA]),
        .start_evt(start_w),
        .stop_evt (stop_w),
        .dev_addr ({DEV_ID, dev_strap}),
        .rd_data  (rd_data),
        .sda_pull (sda_pull),
        .sel      (reg_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );
endmodule

// File: rtl/twi_ptr_slave_chk.sv
// Property checker for the two-wire slave, attached by bind below.
module twi_ptr_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start,
    input logic       stop,
    input logic       sda_pull,
    input logic       wr_en,
    input logic [1:0] reg_sel
);
    // R12: pull-down moves only after an SCL fall or a bus condition
    p_pull_on_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_pull) |-> $past(scl_fall || start || stop));

    // R1: a stop always leaves SDA released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_pull);

    // R13: write strobe is a single cycle
    p_wr_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: no strobe while the read-only register is selected
    p_no_temp_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> reg_sel != 2'd0);

    // R3: the select only changes together with the pointer acknowledge
    p_sel_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(reg_sel) |-> $rose(sda_pull));
endmodule

bind twi_ptr_slave twi_ptr_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_fall(scl_fall_w),
    .start   (start_w),
    .stop    (stop_w),
    .sda_pull(sda_pull),
    .wr_en   (wr_en),
    .reg_sel (reg_sel)
);

// File: tb/tb_twi_ptr_slave.sv
// Directed bench: a bus-master model drives the slave; a small register
// model answers reads and records write strobes.
module tb_twi_ptr_slave;
    localparam int Q = 80;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] AW = {4'b1001, STRAP, 1'b0};
    localparam logic [7:0] AR = {4'b1001, STRAP, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_pull;
    logic [1:0]  reg_sel;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [15:0] regs [4];
    logic [15:0] last_wr;
    int          wr_cnt;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign rd_data = regs[reg_sel];

    twi_ptr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .dev_strap(STRAP), .sda_pull(sda_pull), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // Register model: fixed contents at reset, updated by write strobes.
    always @(posedge clk) begin
        if (!rst_n) begin
            regs[0] <= 16'h1940; regs[1] <= 16'hA500;
            regs[2] <= 16'h4B00; regs[3] <= 16'h5000;
            wr_cnt  <= 0; last_wr <= 16'h0;
        end else if (wr_en) begin
            regs[reg_sel] <= wr_data;
            last_wr       <= wr_data;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask
    task automatic bit_w(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask
    task automatic bit_r(output logic v);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; v = sda_bus; #Q; scl_m = 1'b0; #Q;
    endtask
    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(nack);
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_r(b[i]);
        bit_w(~give_ack);
    endtask

    task automatic t_reset();
        check(16'(sda_pull), 16'h0, "R1 reset pull");
        check(16'(wr_en), 16'h0, "R1 reset strobe");
        check(16'(reg_sel), 16'h0, "R1 reset select");
    endtask

    task automatic t_addr_mismatch();
        logic n;
        int w0 = wr_cnt;
        bus_start();
        send_byte({4'b1001, 3'b010, 1'b0}, n); check(16'(n), 16'h1, "R2 strap mismatch nack");
        send_byte(8'h03, n); check(16'(n), 16'h1, "R2 silent after mismatch");
        bus_stop();
        bus_start();
        send_byte({4'b1101, STRAP, 1'b0}, n); check(16'(n), 16'h1, "R2 nibble mismatch nack");
        bus_stop();
        check(16'(wr_cnt - w0), 16'h0, "R2 no write");
        check(16'(reg_sel), 16'h0, "R2 select kept");
    endtask

    task automatic t_write_two();
        logic n;
        int w0 = wr_cnt;
        bus_start();
        send_byte(AW, n);    check(16'(n), 16'h0, "R2 address ack");
        send_byte(8'h03, n); check(16'(n), 16'h0, "R3 pointer ack");
        send_byte(8'h5A, n); check(16'(n), 16'h0, "R6 first byte ack");
        check(16'(wr_cnt - w0), 16'h0, "R6 no strobe after first byte");
        send_byte(8'h30, n); check(16'(n), 16'h0, "R6 second byte ack");
        bus_stop();
        check(16'(wr_cnt - w0), 16'h1, "R6 one strobe");
        check(last_wr, 16'h5A30, "R6 write data");
        check(16'(reg_sel), 16'h3, "R5 upper select");
    endtask

    task automatic t_bad_ptr();
        logic n;
        int w0 = wr_cnt;
        bus_start();
        send_byte(AW, n);    check(16'(n), 16'h0, "R3 address ack");
        send_byte(8'h06, n); check(16'(n), 16'h1, "R3 bad pointer nack");
        send_byte(8'h12, n); check(16'(n), 16'h1, "R3 abandoned");
        bus_stop();
        check(16'(reg_sel), 16'h3, "R3 select unchanged");
        check(16'(wr_cnt - w0), 16'h0, "R3 no write");
    endtask

    task automatic t_read_persist();
        logic n;
        logic [7:0] hi, lo;
        bus_start();
        send_byte(AR, n); check(16'(n), 16'h0, "R4 read address ack");
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        check({hi, lo}, 16'h5A30, "R4 R9 persistent read");
        bit_r(n); check(16'(n), 16'h1, "R10 released after nack");
        bus_stop();
    endtask

    task automatic t_ptr_restart_read();
        logic n;
        logic [7:0] b;
        bus_start();
        send_byte(AW, n);
        send_byte(8'h01, n); check(16'(n), 16'h0, "R11 pointer ack");
        bus_start();
        send_byte(AR, n); check(16'(n), 16'h0, "R11 read address ack");
        recv_byte(1'b0, b);
        check(16'(b), 16'h00A5, "R11 R9 config byte");
        bit_r(n); check(16'(n), 16'h1, "R5 one byte only");
        bus_stop();
    endtask

    task automatic t_cfg_write();
        logic n;
        int w0 = wr_cnt;
        bus_start();
        send_byte(AW, n); send_byte(8'h01, n);
        send_byte(8'hC3, n); check(16'(n), 16'h0, "R7 data ack");
        check(16'(wr_cnt - w0), 16'h1, "R7 one strobe");
        check(last_wr, 16'hC300, "R7 write data");
        bus_stop();
    endtask

    task automatic t_temp_write();
        logic n;
        logic [7:0] hi, lo;
        int w0 = wr_cnt;
        bus_start();
        send_byte(AW, n); send_byte(8'h00, n);
        send_byte(8'h12, n); check(16'(n), 16'h0, "R8 first ack");
        send_byte(8'h34, n); check(16'(n), 16'h0, "R8 second ack");
        bus_stop();
        check(16'(wr_cnt - w0), 16'h0, "R8 discarded");
        bus_start();
        send_byte(AR, n);
        recv_byte(1'b1, hi); recv_byte(1'b0, lo);
        bus_stop();
        check({hi, lo}, 16'h1940, "R5 R8 temperature read");
    endtask

    task automatic t_partial_write();
        logic n;
        int w0 = wr_cnt;
        bus_start();
        send_byte(AW, n); send_byte(8'h02, n);
        send_byte(8'h77, n); check(16'(n), 16'h0, "R6 partial ack");
        bus_stop();
        check(16'(wr_cnt - w0), 16'h0, "R6 partial dropped");
        check(16'(reg_sel), 16'h2, "R5 lower select");
    endtask

    task automatic t_restart_mid();
        logic n;
        logic [7:0] hi, lo;
        bus_start();
        bit_w(1'b1); bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
        bus_start();
        send_byte(AR, n); check(16'(n), 16'h0, "R1 restart address ack");
        recv_byte(1'b1, hi); recv_byte(1'b0, lo);
        bus_stop();
        check({hi, lo}, 16'h4B00, "R1 R9 lower threshold read");
        check(16'(sda_pull), 16'h0, "R1 released after stop");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #3 rst_n = 1'b1;
        #(4*Q);
        t_reset();
        t_addr_mismatch();
        t_write_two();
        t_bad_ptr();
        t_read_persist();
        t_ptr_restart_read();
        t_cfg_write();
        t_temp_write();
        t_partial_write();
        t_restart_mid();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(150000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule